// File: doc/BRIEF.md
# MDIO Management Frame Master

This block runs clause-22 management transfers towards an external PHY. Software composes a complete 32-bit frame word and writes it to the frame register. That word carries the start code, the opcode, the PHY address, the register address, the turnaround field and the data. The block serialises the word on MDC/MDIO, optionally after a preamble of 32 ones. On a read, it lets go of MDIO so the PHY can drive the data phase. The 16 bits it collects are written back into the low half of the frame register, where software reads them.

A second register holds the timing settings. These are the MDC half-period divider, a preamble-suppress flag, and the number of module-clock cycles that MDIO changes lag behind each MDC falling edge. A one-cycle `done` pulse marks the end of each frame, and `busy` is high while a frame is on the wire.

Top module: `mdio_master`

## Requirements
- R1: Frame word layout: bits 31:30 start code (01), 29:28 opcode (10 = read; 01 and any other value = write), 27:23 PHY address, 22:18 register address, 17:16 turnaround (10), 15:0 data. Frame bits go out most significant bit first, one per MDC period, with the value presented at the MDC rising edge.
- R2: A frame has 32 one bits of preamble ahead of bit 31, unless bit 7 of the timing register is set. When it is set, the frame has only its 32 frame bits.
- R3: With SPEED in bits 6:1 of the timing register, MDC has period 2*(SPEED+1) module clocks. Each transfer starts with a low half-period, and MDC is low whenever `busy` is low.
- R4: A frame-register write with SPEED equal to zero stores the word but starts no transfer: `busy` stays low and MDC does not toggle.
- R5: With HOLD in bits 10:8 of the timing register, `mdio_o` and `mdio_oe` take each new bit HOLD+1 module clocks after the MDC falling edge that ends the previous bit. HOLD must not exceed SPEED.
- R6: On a read, `mdio_oe` is low from frame bit 16 through frame bit 0. `mdio_i` is sampled at each MDC rising edge of frame bits 15..0. At completion those 16 bits replace bits 15:0 of the frame register, and bits 31:16 are kept.
- R7: `done` is a single-cycle pulse issued at the final MDC falling edge of a frame. `busy` drops in the same cycle.
- R8: A frame-register write while `busy` is high is ignored: the stored word and the bits on the wire are unchanged.
- R9: After reset, MDC is low, `mdio_oe` is low, `mdio_o` is high, `busy` and `done` are low, and both registers read zero. Register selector: `wr_addr`/`rd_addr` 0 = frame word, 1 = timing word.
- R10: After a frame completes, `mdio_oe` returns low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write target: 0 frame, 1 timing |
| wr_data | input | 32 | Write data |
| rd_addr | input | 1 | Read target: 0 frame, 1 timing |
| rd_data | output | 32 | Read data |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data drive enable |
| mdio_i | input | 1 | Management data in |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Frame complete pulse |

## Verification
If the bit index is off by one, the captured MDIO stream is shifted or the bit count is wrong. This is visible at the next MDC rising edge, or by the done pulse at the latest. A divider or edge-detect fault changes the MDC rise-to-rise spacing within two periods. A wrong hold counter moves the first falling transition of MDIO relative to the preceding MDC fall. A bad read window shows up as a wrong drive-enable pattern during the frame. Errors in the sample shift or the write-back appear in the frame readback right after `done`.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_W  = 32;
  localparam int PRE_BITS = 32;
  localparam int DATA_W   = 16;
  localparam int DIV_W    = 6;
  localparam int HOLD_W   = 3;

  // opcode field position inside the frame word
  localparam int OP_LSB = 28;

  typedef enum logic [1:0] {
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10
  } mdio_op_e;

  typedef enum logic {
    SEL_FRAME = 1'b0,
    SEL_TIMING = 1'b1
  } mdio_sel_e;
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int DIV_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] half,
  output logic             mdc,
  output logic             rise_p,
  output logic             fall_p
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             mdc_q, mdc_d;
  logic             tick;

  assign tick = en && (cnt_q == half);

  always_comb begin
    cnt_d = cnt_q;
    mdc_d = mdc_q;
    if (!en) begin
      cnt_d = '0;
      mdc_d = 1'b0;
    end else if (tick) begin
      cnt_d = '0;
      mdc_d = ~mdc_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end

  assign mdc    = mdc_q;
  assign rise_p = tick & ~mdc_q;
  assign fall_p = tick & mdc_q;
endmodule

// File: rtl/mdio_hold.sv
module mdio_hold #(
  parameter int HOLD_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              ld_val,
  input  logic              ld_oe,
  input  logic [HOLD_W-1:0] hold,
  output logic              mdio_o,
  output logic              mdio_oe
);
  logic              pend_q, pend_d;
  logic              val_q, val_d;
  logic              oe_q, oe_d;
  logic [HOLD_W-1:0] cnt_q, cnt_d;
  logic              out_q, out_d;
  logic              oeo_q, oeo_d;

  always_comb begin
    pend_d = pend_q;
    val_d  = val_q;
    oe_d   = oe_q;
    cnt_d  = cnt_q;
    out_d  = out_q;
    oeo_d  = oeo_q;
    if (load) begin
      pend_d = 1'b1;
      val_d  = ld_val;
      oe_d   = ld_oe;
      cnt_d  = hold;
    end else if (pend_q) begin
      if (cnt_q == '0) begin
        pend_d = 1'b0;
        out_d  = val_q;
        oeo_d  = oe_q;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      val_q  <= 1'b1;
      oe_q   <= 1'b0;
      cnt_q  <= '0;
      out_q  <= 1'b1;
      oeo_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      val_q  <= val_d;
      oe_q   <= oe_d;
      cnt_q  <= cnt_d;
      out_q  <= out_d;
      oeo_q  <= oeo_d;
    end
  end

  assign mdio_o  = out_q;
  assign mdio_oe = oeo_q;
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int DIV_W  = mdio_pkg::DIV_W,
  parameter int HOLD_W = mdio_pkg::HOLD_W
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        wr_addr,
  input  logic [31:0] wr_data,
  input  logic        rd_addr,
  output logic [31:0] rd_data,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i,
  output logic        busy,
  output logic        done
);
  localparam int NOPRE_BIT = DIV_W + 1;
  localparam int HOLD_LSB  = DIV_W + 2;
  localparam int CFG_W     = HOLD_LSB + HOLD_W;
  localparam int IDX_W     = $clog2(PRE_BITS + FRAME_W);
  localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(PRE_BITS + FRAME_W - 1);
  localparam logic [IDX_W-1:0] FIRST_FRM = IDX_W'(PRE_BITS);
  localparam logic [IDX_W-1:0] REL_IDX   = IDX_W'(PRE_BITS + FRAME_W - DATA_W - 1);
  localparam logic [IDX_W-1:0] DATA_IDX  = IDX_W'(PRE_BITS + FRAME_W - DATA_W);

  logic [FRAME_W-1:0] frame_q, frame_d;
  logic [CFG_W-1:0]   spd_q, spd_d;
  logic               busy_q, busy_d;
  logic [IDX_W-1:0]   bit_q, bit_d;
  logic [DATA_W-1:0]  rsh_q, rsh_d;
  logic               done_q, done_d;

  logic [DIV_W-1:0]  spd_div;
  logic              nopre;
  logic [HOLD_W-1:0] hold_cyc;
  logic              is_rd, wr_frame, start, last;
  logic              rise_p, fall_p;
  logic              ld, ld_val, ld_oe;
  logic [IDX_W-1:0]  nxt;

  assign spd_div  = spd_q[DIV_W:1];
  assign nopre    = spd_q[NOPRE_BIT];
  assign hold_cyc = spd_q[HOLD_LSB +: HOLD_W];
  assign is_rd    = (frame_q[OP_LSB +: 2] == OP_READ);
  assign wr_frame = wr_en && (wr_addr == SEL_FRAME);
  assign start    = wr_frame && !busy_q && (spd_div != '0);
  assign last     = (bit_q == LAST_IDX);
  assign nxt      = bit_q + 1'b1;

  // wire value for a position in the preamble+frame sequence
  function automatic logic seq_bit(input logic [FRAME_W-1:0] f,
                                   input logic [IDX_W-1:0] idx);
    if (idx >= FIRST_FRM) return f[LAST_IDX - idx];
    return 1'b1;
  endfunction

  always_comb begin
    frame_d = frame_q;
    spd_d   = spd_q;
    busy_d  = busy_q;
    bit_d   = bit_q;
    rsh_d   = rsh_q;
    done_d  = 1'b0;
    ld      = 1'b0;
    ld_val  = 1'b1;
    ld_oe   = 1'b0;
    if (wr_en && (wr_addr == SEL_TIMING)) spd_d = wr_data[CFG_W-1:0];
    if (wr_frame && !busy_q) frame_d = wr_data;
    if (start) begin
      busy_d = 1'b1;
      bit_d  = nopre ? FIRST_FRM : '0;
      ld     = 1'b1;
      ld_val = nopre ? wr_data[FRAME_W-1] : 1'b1;
      ld_oe  = 1'b1;
    end
    if (busy_q && rise_p && is_rd && (bit_q >= DATA_IDX))
      rsh_d = {rsh_q[DATA_W-2:0], mdio_i};
    if (busy_q && fall_p) begin
      ld = 1'b1;
      if (last) begin
        busy_d = 1'b0;
        done_d = 1'b1;
        ld_val = 1'b1;
        ld_oe  = 1'b0;
        if (is_rd) frame_d = {frame_q[FRAME_W-1:DATA_W], rsh_q};
      end else begin
        bit_d  = nxt;
        ld_val = seq_bit(frame_q, nxt);
        ld_oe  = !(is_rd && (nxt >= REL_IDX));
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= '0;
      spd_q   <= '0;
      busy_q  <= 1'b0;
      bit_q   <= '0;
      rsh_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      frame_q <= frame_d;
      spd_q   <= spd_d;
      busy_q  <= busy_d;
      bit_q   <= bit_d;
      rsh_q   <= rsh_d;
      done_q  <= done_d;
    end
  end

  mdio_clkgen #(.DIV_W(DIV_W)) u_clkgen (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (busy_q),
    .half   (spd_div),
    .mdc    (mdc),
    .rise_p (rise_p),
    .fall_p (fall_p)
  );

  mdio_hold #(.HOLD_W(HOLD_W)) u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (ld),
    .ld_val  (ld_val),
    .ld_oe   (ld_oe),
    .hold    (hold_cyc),
    .mdio_o  (mdio_o),
    .mdio_oe (mdio_oe)
  );

  assign rd_data = (rd_addr == SEL_TIMING) ? {{(32-CFG_W){1'b0}}, spd_q} : frame_q;
  assign busy    = busy_q;
  assign done    = done_q;
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        done,
  input logic        mdc,
  input logic        wr_en,
  input logic        wr_addr,
  input logic        div_zero,
  input logic [15:0] frame_hi
);
  AST_IDLE_MDC_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc); // R3

  AST_DIV0_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_addr && div_zero && !busy) |=> !busy); // R4

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7

  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy))); // R7

  AST_BUSY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_en && !wr_addr) |=> $stable(frame_hi)); // R8
endmodule

bind mdio_master mdio_master_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (busy),
  .done     (done),
  .mdc      (mdc),
  .wr_en    (wr_en),
  .wr_addr  (wr_addr),
  .div_zero (spd_div == '0),
  .frame_hi (frame_q[31:16])
);

// File: tb/mdio_master_tb.sv
`timescale 1ns/1ps
module mdio_master_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_addr = 1'b0;
  logic [31:0] wr_data = '0;
  logic        rd_addr = 1'b0;
  logic [31:0] rd_data;
  logic        mdc, mdio_o, mdio_oe, mdio_i, busy, done;

  int tests = 0;
  int fails = 0;

  // monitor state
  int          cyc = 0;
  int          nrise = 0;
  int          ndone = 0;
  int          rise_cyc = 0;
  int          rise_prev = 0;
  int          fall_cyc = 0;
  int          chg_dly = -1;
  logic [63:0] cap_o = '0;
  logic [63:0] cap_oe = '0;
  logic        mdc_d = 1'b0;
  logic        o_d = 1'b1;

  // PHY model
  logic        tb_nopre = 1'b0;
  logic [15:0] phy_val = '0;

  always #2.5 clk = ~clk;

  mdio_master u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i),
    .busy(busy), .done(done)
  );

  function automatic logic phy_bit(int r, logic np, logic [15:0] v);
    int idx;
    idx = r + (np ? 32 : 0);
    if (idx >= 48 && idx <= 63) return v[63 - idx];
    return 1'b1;
  endfunction

  assign mdio_i = phy_bit(nrise, tb_nopre, phy_val);

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (mdc && !mdc_d) begin
      cap_o  = {cap_o[62:0], mdio_o};
      cap_oe = {cap_oe[62:0], mdio_oe};
      nrise  = nrise + 1;
      rise_prev = rise_cyc;
      rise_cyc  = cyc;
    end
    if (!mdc && mdc_d) fall_cyc = cyc;
    if (!mdio_o && o_d && busy && chg_dly < 0) chg_dly = cyc - fall_cyc;
    if (done) ndone = ndone + 1;
    mdc_d = mdc;
    o_d   = mdio_o;
    if (cyc > 150000) begin
      tests = tests + 1;
      fails = fails + 1;
      $display("FAIL watchdog: run did not finish, cyc=%0d expected<=150000", cyc);
      summary();
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    tests = tests + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clr_mon();
    nrise = 0; ndone = 0; chg_dly = -1;
    cap_o = '0; cap_oe = '0;
    rise_cyc = 0; rise_prev = 0;
  endtask

  task automatic reg_wr(input logic a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic reg_rd(input logic a, output logic [31:0] d);
    @(negedge clk);
    rd_addr = a;
    #1 d = rd_data;
  endtask

  function automatic logic [31:0] timing(int s, int h, bit np);
    return (32'(h) << 8) | (np ? 32'h80 : 32'h0) | (32'(s) << 1);
  endfunction

  task automatic wait_done();
    int n = 0;
    while (ndone == 0 && n < 20000) begin
      @(negedge clk);
      n++;
    end
    repeat (10) @(negedge clk);
  endtask

  // R9
  task automatic t_reset();
    logic [31:0] d;
    chk(!mdc, "R9 mdc", 64'(mdc), 0);
    chk(!mdio_oe, "R9 oe", 64'(mdio_oe), 0);
    chk(mdio_o, "R9 mdio_o", 64'(mdio_o), 1);
    chk(!busy && !done, "R9 busy/done", {busy, done}, 0);
    reg_rd(1'b0, d); chk(d == 0, "R9 frame reg", d, 0);
    reg_rd(1'b1, d); chk(d == 0, "R9 timing reg", d, 0);
  endtask

  // R1 R2 R3 R7 R10
  task automatic t_write(int s, int h, bit np, logic [31:0] fr);
    logic [63:0] exp;
    int nb;
    tb_nopre = np;
    reg_wr(1'b1, timing(s, h, np));
    clr_mon();
    reg_wr(1'b0, fr);
    wait_done();
    nb  = np ? 32 : 64;
    exp = np ? {32'h0, fr} : {32'hFFFF_FFFF, fr};
    chk(nrise == nb, "R2 bit count", 64'(nrise), 64'(nb));
    chk((np ? {32'h0, cap_o[31:0]} : cap_o) == exp, "R1 serial stream", cap_o, exp);
    chk((np ? {32'h0, cap_oe[31:0]} : cap_oe) == (np ? 64'hFFFF_FFFF : '1),
        "R1 driven all frame", cap_oe, '1);
    chk(rise_cyc - rise_prev == 2 * (s + 1), "R3 mdc period",
        64'(rise_cyc - rise_prev), 64'(2 * (s + 1)));
    chk(ndone == 1, "R7 single done", 64'(ndone), 1);
    chk(!busy && !mdc, "R7 idle after done", {busy, mdc}, 0);
    chk(!mdio_oe, "R10 release after frame", 64'(mdio_oe), 0);
  endtask

  // R5
  task automatic t_hold(int s, int h);
    tb_nopre = 1'b0;
    reg_wr(1'b1, timing(s, h, 1'b0));
    clr_mon();
    reg_wr(1'b0, 32'h5000_0000);
    wait_done();
    chk(chg_dly == h + 1, "R5 hold delay", 64'(chg_dly), 64'(h + 1));
  endtask

  // R6
  task automatic t_read(int s, int h, bit np, logic [15:0] v);
    logic [31:0] fr, d;
    logic [63:0] exp_oe;
    fr = {2'b01, 2'b10, 5'h03, 5'h02, 2'b10, 16'h0000};
    tb_nopre = np;
    phy_val  = v;
    reg_wr(1'b1, timing(s, h, np));
    clr_mon();
    reg_wr(1'b0, fr);
    wait_done();
    reg_rd(1'b0, d);
    chk(d[15:0] == v, "R6 read data", d[15:0], v);
    chk(d[31:16] == fr[31:16], "R6 header kept", d[31:16], fr[31:16]);
    exp_oe = np ? 64'hFFFE_0000 : ~64'h1FFFF;
    chk((np ? {32'h0, cap_oe[31:0]} : cap_oe) == exp_oe, "R6 release window",
        cap_oe, exp_oe);
    chk(ndone == 1, "R7 done on read", 64'(ndone), 1);
  endtask

  // R4
  task automatic t_div0();
    logic [31:0] d;
    reg_wr(1'b1, timing(0, 0, 1'b0));
    clr_mon();
    reg_wr(1'b0, 32'h5555_1234);
    repeat (60) @(negedge clk);
    chk(!busy && nrise == 0, "R4 no transfer", {busy, 32'(nrise)}, 0);
    reg_rd(1'b0, d);
    chk(d == 32'h5555_1234, "R4 word stored", d, 32'h5555_1234);
  endtask

  // R8
  task automatic t_busy_write();
    logic [31:0] a, d;
    a = {2'b01, 2'b01, 5'h1F, 5'h11, 2'b10, 16'h0F0F};
    tb_nopre = 1'b0;
    reg_wr(1'b1, timing(2, 1, 1'b0));
    clr_mon();
    reg_wr(1'b0, a);
    repeat (40) @(negedge clk);
    reg_wr(1'b0, 32'h6AAA_FFFF);
    wait_done();
    reg_rd(1'b0, d);
    chk(d == a, "R8 stored word kept", d, a);
    chk(cap_o == {32'hFFFF_FFFF, a}, "R8 stream kept", cap_o, {32'hFFFF_FFFF, a});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write(3, 1, 1'b0, {2'b01, 2'b01, 5'h11, 5'h0A, 2'b10, 16'hA53C});
    t_write(1, 0, 1'b1, {2'b01, 2'b01, 5'h06, 5'h15, 2'b10, 16'h3C96});
    t_hold(5, 3);
    t_hold(2, 0);
    t_read(2, 1, 1'b0, 16'hC3A5);
    t_read(4, 2, 1'b1, 16'h5A81);
    t_div0();
    t_busy_write();
    summary();
  end
endmodule